// File: doc/BRIEF.md
# March Algorithm Memory Self-Test Controller

This block tests a one-bit-wide RAM of 2^AW cells with march algorithms. An algorithm is a short list of march elements. Each element sweeps the whole address space, either from the lowest cell upward or from the highest cell downward. At every cell it applies its own sequence of one to six read or write operations, and only then steps to the next cell. A read carries the value it expects. The controller compares the returned bit against that value one cycle after it issues the read, which matches a RAM with a registered read port.

The test is chosen with `algoSel` and launched by holding `start` high for a cycle while the controller is idle or finished. While the sweep runs, `busy` is high and the controller drives the memory enable, write enable, address and write data directly. The first read that returns the wrong bit sets `fail` and records its address and the index of the element that issued it. Elements are counted from zero. The `stopOnFail` input chooses whether the run halts at that point or completes all elements. At the end `done` rises and stays high until the next start.

Top module: `march_bist`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `fail`, `memEn` and `memWe` are 0 until a start is accepted.
- R2: `algoSel` picks the algorithm. The "any order" elements are run ascending. Encodings: 0 = MATS+ {w0; up(r0,w1); down(r1,w0)}; 1 = MATS++ {w0; up(r0,w1); down(r1,w0,r0)}; 2 = March X {w0; up(r0,w1); down(r1,w0); up(r0)}; 3 = March C- {w0; up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0)}; 4 = March Y {w0; up(r0,w1,r1); down(r1,w0,r0); up(r0)}; 5 = March A {w0; up(r0,w1,w0,w1); up(r1,w0,w1); down(r1,w0,w1,w0); down(r0,w1,w0)}; 6 and 7 run MATS+.
- R3: An ascending element visits addresses 0 to 2^AW-1 and a descending element visits 2^AW-1 down to 0. All operations of an element are applied to one address on consecutive cycles before the address moves.
- R4: Exactly one operation is issued in each cycle in which `memEn` is 1. A read has `memWe`=0. A write has `memWe`=1, with the written bit on `memWdata`. `memWe` is never 1 while `memEn` is 0.
- R5: A fault-free run issues one operation per cycle with no gaps, in total the element operation counts times 2^AW (for example 10n for March C- and 8n for March Y).
- R6: A read is compared with its expected bit in the following cycle. On the first mismatch of a run, `fail` is set, and `failAddr` and `failElem` take the address and zero-based element index of that read. Later mismatches do not change them.
- R7: With `stopOnFail`=1, at most one further operation is issued after the failing read. The controller then shows `done`=1 and `busy`=0.
- R8: With `stopOnFail`=0, a failing run still issues every operation of the algorithm. `fail` stays set until the next start.
- R9: `start` is sampled only while idle or done. A start seen while busy has no effect on the operation sequence. `done` holds until a new start is accepted, and an accepted start clears `fail`.
- R10: `busy` is 1 from the cycle after start is accepted until the run ends. `done` and `busy` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Level-sampled launch request |
| algoSel | input | 3 | Algorithm choice (see R2) |
| stopOnFail | input | 1 | 1 halts at the first mismatch, 0 completes the run |
| memEn | output | 1 | Memory access strobe, one operation per cycle |
| memWe | output | 1 | Write enable (1 write, 0 read) |
| memAddr | output | AW | Memory address |
| memWdata | output | 1 | Bit to write |
| memRdata | input | 1 | Read data, valid the cycle after the read |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, held until next start |
| fail | output | 1 | At least one read mismatch seen |
| failAddr | output | AW | Address of the first mismatching read |
| failElem | output | 3 | Element index of the first mismatching read |

## Verification
On every cycle the assertions check these invariants: the write enable only appears under the access strobe, done and busy never overlap, done and fail persist without a start, and the captured failure address never moves while fail stays high. They also check that the address only steps by one or jumps to an end between operations, and that a run with stop-on-fail issues nothing once fail rises. The exact operation order of each algorithm, the operation totals, and which cell and element are blamed for a stuck cell or an aliased address can only be shown by the scenarios. There the bench runs its own model of a faulty memory and expands each algorithm independently.

// File: rtl/march_pkg.sv
package march_pkg;

  localparam int OPS_MAX = 6;
  localparam int ELEM_W  = 3;
  localparam int OPIX_W  = 3;
  localparam int ALGO_W  = 3;

  typedef struct packed {
    logic isWrite;
    logic val;
  } marchOp_t;

  typedef struct packed {
    logic                  last;
    logic                  down;
    logic [OPIX_W-1:0]     nOps;
    marchOp_t [OPS_MAX-1:0] ops;
  } marchElem_t;

  typedef struct packed {
    logic clear;
    logic loadAddr;
    logic loadDown;
    logic step;
    logic rdIssue;
    logic rdExp;
  } dpStrobe_t;

  localparam marchOp_t RD0 = '{isWrite: 1'b0, val: 1'b0};
  localparam marchOp_t RD1 = '{isWrite: 1'b0, val: 1'b1};
  localparam marchOp_t WR0 = '{isWrite: 1'b1, val: 1'b0};
  localparam marchOp_t WR1 = '{isWrite: 1'b1, val: 1'b1};

  function automatic marchElem_t mkElem(input logic last, input logic down,
                                        input logic [OPIX_W-1:0] n,
                                        input marchOp_t a, input marchOp_t b = '0,
                                        input marchOp_t c = '0, input marchOp_t d = '0,
                                        input marchOp_t f = '0, input marchOp_t g = '0);
    marchElem_t r;
    r.last = last;
    r.down = down;
    r.nOps = n;
    r.ops  = {g, f, d, c, b, a};
    return r;
  endfunction

  function automatic marchElem_t algoElem(input logic [ALGO_W-1:0] algo,
                                          input logic [ELEM_W-1:0] idx);
    marchElem_t r;
    r = mkElem(1'b0, 1'b0, 3'd1, WR0);
    case (algo)
      3'd1: case (idx)
        3'd0: r = mkElem(1'b0, 1'b0, 3'd1, WR0);
        3'd1: r = mkElem(1'b0, 1'b0, 3'd2, RD0, WR1);
        default: r = mkElem(1'b1, 1'b1, 3'd3, RD1, WR0, RD0);
      endcase
      3'd2: case (idx)
        3'd0: r = mkElem(1'b0, 1'b0, 3'd1, WR0);
        3'd1: r = mkElem(1'b0, 1'b0, 3'd2, RD0, WR1);
        3'd2: r = mkElem(1'b0, 1'b1, 3'd2, RD1, WR0);
        default: r = mkElem(1'b1, 1'b0, 3'd1, RD0);
      endcase
      3'd3: case (idx)
        3'd0: r = mkElem(1'b0, 1'b0, 3'd1, WR0);
        3'd1: r = mkElem(1'b0, 1'b0, 3'd2, RD0, WR1);
        3'd2: r = mkElem(1'b0, 1'b0, 3'd2, RD1, WR0);
        3'd3: r = mkElem(1'b0, 1'b1, 3'd2, RD0, WR1);
        3'd4: r = mkElem(1'b0, 1'b1, 3'd2, RD1, WR0);
        default: r = mkElem(1'b1, 1'b0, 3'd1, RD0);
      endcase
      3'd4: case (idx)
        3'd0: r = mkElem(1'b0, 1'b0, 3'd1, WR0);
        3'd1: r = mkElem(1'b0, 1'b0, 3'd3, RD0, WR1, RD1);
        3'd2: r = mkElem(1'b0, 1'b1, 3'd3, RD1, WR0, RD0);
        default: r = mkElem(1'b1, 1'b0, 3'd1, RD0);
      endcase
      3'd5: case (idx)
        3'd0: r = mkElem(1'b0, 1'b0, 3'd1, WR0);
        3'd1: r = mkElem(1'b0, 1'b0, 3'd4, RD0, WR1, WR0, WR1);
        3'd2: r = mkElem(1'b0, 1'b0, 3'd3, RD1, WR0, WR1);
        3'd3: r = mkElem(1'b0, 1'b1, 3'd4, RD1, WR0, WR1, WR0);
        default: r = mkElem(1'b1, 1'b1, 3'd3, RD0, WR1, WR0);
      endcase
      default: case (idx)
        3'd0: r = mkElem(1'b0, 1'b0, 3'd1, WR0);
        3'd1: r = mkElem(1'b0, 1'b0, 3'd2, RD0, WR1);
        default: r = mkElem(1'b1, 1'b1, 3'd2, RD1, WR0);
      endcase
    endcase
    return r;
  endfunction

  function automatic logic elemDown(input logic [ALGO_W-1:0] algo,
                                    input logic [ELEM_W-1:0] idx);
    marchElem_t r;
    r = algoElem(algo, idx);
    return r.down;
  endfunction

endpackage

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ALGO_W-1:0] algoSel,
  input  logic              stopOnFail,
  input  logic              addrLast,
  input  logic              mismatch,
  output dpStrobe_t         strobe,
  output logic [ELEM_W-1:0] elemIdx,
  output logic              memEn,
  output logic              memWe,
  output logic              memWdata,
  output logic              busy,
  output logic              done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FLUSH, S_DONE} state_t;

  state_t            stateQ, stateD;
  logic [ELEM_W-1:0] elemQ, elemD;
  logic [OPIX_W-1:0] opQ, opD;
  logic [ALGO_W-1:0] algoQ, algoD;
  marchElem_t        curElem;
  marchOp_t          curOp;
  logic              nextDown, firstDown;

  assign curElem   = algoElem(algoQ, elemQ);
  assign curOp     = curElem.ops[opQ];
  assign nextDown  = elemDown(algoQ, elemQ + 3'd1);
  assign firstDown = elemDown(algoSel, '0);

  always_comb begin
    stateD   = stateQ;
    elemD    = elemQ;
    opD      = opQ;
    algoD    = algoQ;
    strobe   = '0;
    memEn    = 1'b0;
    memWe    = 1'b0;
    memWdata = 1'b0;
    case (stateQ)
      S_IDLE, S_DONE: begin
        if (start) begin
          stateD          = S_RUN;
          elemD           = '0;
          opD             = '0;
          algoD           = algoSel;
          strobe.clear    = 1'b1;
          strobe.loadAddr = 1'b1;
          strobe.loadDown = firstDown;
        end
      end
      S_RUN: begin
        memEn          = 1'b1;
        memWe          = curOp.isWrite;
        memWdata       = curOp.val;
        strobe.rdIssue = ~curOp.isWrite;
        strobe.rdExp   = curOp.val;
        if (mismatch && stopOnFail) begin
          stateD = S_DONE;
        end else if (opQ == curElem.nOps - 3'd1) begin
          opD = '0;
          if (addrLast) begin
            if (curElem.last) begin
              stateD = S_FLUSH;
            end else begin
              elemD           = elemQ + 3'd1;
              strobe.loadAddr = 1'b1;
              strobe.loadDown = nextDown;
            end
          end else begin
            strobe.step = 1'b1;
          end
        end else begin
          opD = opQ + 3'd1;
        end
      end
      default: stateD = S_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      elemQ  <= '0;
      opQ    <= '0;
      algoQ  <= '0;
    end else begin
      stateQ <= stateD;
      elemQ  <= elemD;
      opQ    <= opD;
      algoQ  <= algoD;
    end
  end

  assign elemIdx = elemQ;
  assign busy    = (stateQ == S_RUN) || (stateQ == S_FLUSH);
  assign done    = (stateQ == S_DONE);

endmodule

// File: rtl/march_dp.sv
module march_dp
  import march_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ELEM_W-1:0] elemIdx,
  input  logic              memRdata,
  output logic [AW-1:0]     addr,
  output logic              addrLast,
  output logic              mismatch,
  output logic              fail,
  output logic [AW-1:0]     failAddr,
  output logic [ELEM_W-1:0] failElem
);

  localparam logic [AW-1:0] ADDR_MAX = '1;

  logic [AW-1:0]     addrQ, rdAddrQ;
  logic              downQ, rdPendQ, rdExpQ;
  logic [ELEM_W-1:0] rdElemQ;

  assign addr     = addrQ;
  assign addrLast = downQ ? (addrQ == '0) : (addrQ == ADDR_MAX);
  assign mismatch = rdPendQ && (memRdata != rdExpQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      downQ <= 1'b0;
    end else if (strobe.loadAddr) begin
      addrQ <= strobe.loadDown ? ADDR_MAX : '0;
      downQ <= strobe.loadDown;
    end else if (strobe.step) begin
      addrQ <= downQ ? addrQ - 1'b1 : addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPendQ <= 1'b0;
      rdExpQ  <= 1'b0;
      rdAddrQ <= '0;
      rdElemQ <= '0;
    end else begin
      rdPendQ <= strobe.rdIssue;
      rdExpQ  <= strobe.rdExp;
      rdAddrQ <= addrQ;
      rdElemQ <= elemIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fail     <= 1'b0;
      failAddr <= '0;
      failElem <= '0;
    end else if (strobe.clear) begin
      fail     <= 1'b0;
      failAddr <= '0;
      failElem <= '0;
    end else if (mismatch && !fail) begin
      fail     <= 1'b1;
      failAddr <= rdAddrQ;
      failElem <= rdElemQ;
    end
  end

endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ALGO_W-1:0] algoSel,
  input  logic              stopOnFail,
  output logic              memEn,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic              memWdata,
  input  logic              memRdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [AW-1:0]     failAddr,
  output logic [ELEM_W-1:0] failElem
);

  dpStrobe_t         strobe;
  logic [ELEM_W-1:0] elemIdx;
  logic              addrLast, mismatch;

  march_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .algoSel(algoSel),
    .stopOnFail(stopOnFail), .addrLast(addrLast), .mismatch(mismatch),
    .strobe(strobe), .elemIdx(elemIdx), .memEn(memEn), .memWe(memWe),
    .memWdata(memWdata), .busy(busy), .done(done)
  );

  march_dp #(.AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .elemIdx(elemIdx),
    .memRdata(memRdata), .addr(memAddr), .addrLast(addrLast),
    .mismatch(mismatch), .fail(fail), .failAddr(failAddr), .failElem(failElem)
  );

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          stopOnFail,
  input logic          memEn,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [AW-1:0] failAddr
);

  localparam logic [AW-1:0] TOP = '1;

  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn); // R4

  AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy)); // R10

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done); // R9

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fail && !start |=> fail); // R8

  AST_FAILADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    fail && $past(fail) |-> $stable(failAddr)); // R6

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) && $past(stopOnFail) |-> !memEn); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memEn && $past(memEn) && (memAddr != $past(memAddr)) |->
      (memAddr == $past(memAddr) + 1'b1) || (memAddr == $past(memAddr) - 1'b1) ||
      (memAddr == '0) || (memAddr == TOP)); // R3

endmodule

bind march_bist march_bist_chk #(.AW(AW)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .stopOnFail(stopOnFail),
  .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .busy(busy),
  .done(done), .fail(fail), .failAddr(failAddr)
);

// File: tb/march_bist_tb_top.sv
module march_bist_tb_top;

  localparam int AW = 4;
  localparam int N  = 1 << AW;

  typedef struct {
    logic [AW-1:0] a;
    logic          we;
    logic          wd;
  } item_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    algoSel = '0;
  logic          stopOnFail = 1'b0;
  logic          memEn, memWe, memWdata, busy, done, fail;
  logic          memRdata = 1'b0;
  logic [AW-1:0] memAddr, failAddr;
  logic [2:0]    failElem;

  int     checks = 0;
  int     errors = 0;
  int     issued = 0;
  item_t  expQ[$];
  logic   ram[N];
  int     faultKind = 0;
  int     faultA = 0;
  int     faultB = 0;

  always #5 clk = ~clk;

  march_bist #(.AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .algoSel(algoSel),
    .stopOnFail(stopOnFail), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .busy(busy), .done(done),
    .fail(fail), .failAddr(failAddr), .failElem(failElem)
  );

  function automatic int phys(input int a);
    return (faultKind == 2 && a == faultA) ? faultB : a;
  endfunction

  function automatic bit stuckCell(input int p);
    return faultKind == 1 && p == faultA;
  endfunction

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) begin
        if (!stuckCell(phys(int'(memAddr)))) ram[phys(int'(memAddr))] <= memWdata;
      end else begin
        memRdata <= stuckCell(phys(int'(memAddr))) ? faultB[0] : ram[phys(int'(memAddr))];
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && memEn) begin
      issued++;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R7 extra operation: got addr=%0d we=%b expected none", memAddr, memWe);
      end else begin
        item_t e;
        e = expQ.pop_front();
        if (memAddr != e.a || memWe != e.we || (e.we && memWdata != e.wd)) begin
          errors++;
          $display("FAIL R3 op %0d: got addr=%0d we=%b wd=%b expected addr=%0d we=%b wd=%b",
                   issued, memAddr, memWe, memWdata, e.a, e.we, e.wd);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic string algoText(input int algo);
    case (algo)
      1: return "Uw0;Ur0w1;Dr1w0r0";
      2: return "Uw0;Ur0w1;Dr1w0;Ur0";
      3: return "Uw0;Ur0w1;Ur1w0;Dr0w1;Dr1w0;Ur0";
      4: return "Uw0;Ur0w1r1;Dr1w0r0;Ur0";
      5: return "Uw0;Ur0w1w0w1;Ur1w0w1;Dr1w0w1w0;Dr0w1w0";
      default: return "Uw0;Ur0w1;Dr1w0";
    endcase
  endfunction

  task automatic buildPlan(input int algo, input bit stop, output int total,
                           output bit eFail, output int eAddr, output int eElem);
    string s;
    int    nEl;
    bit    dn[8];
    int    nOp[8];
    bit    ow[8][6];
    bit    ov[8][6];
    bit    sim[N];
    int    idx, fIdx;
    s = algoText(algo);
    nEl = 0;
    for (int i = 0; i < s.len(); i++) begin
      if (s[i] == "U" || s[i] == "D") begin
        dn[nEl] = (s[i] == "D");
        nOp[nEl] = 0;
        nEl++;
      end else if (s[i] == "r" || s[i] == "w") begin
        ow[nEl-1][nOp[nEl-1]] = (s[i] == "w");
        ov[nEl-1][nOp[nEl-1]] = (s[i+1] == "1");
        nOp[nEl-1]++;
      end
    end
    for (int c = 0; c < N; c++) sim[c] = 1'b0;
    expQ.delete();
    idx = 0; fIdx = -1; eAddr = 0; eElem = 0;
    for (int e = 0; e < nEl; e++) begin
      for (int k = 0; k < N; k++) begin
        int a;
        a = dn[e] ? N - 1 - k : k;
        for (int o = 0; o < nOp[e]; o++) begin
          item_t it;
          it.a = AW'(a); it.we = ow[e][o]; it.wd = ov[e][o];
          expQ.push_back(it);
          if (!ow[e][o]) begin
            bit got;
            got = stuckCell(phys(a)) ? faultB[0] : sim[phys(a)];
            if (got != ov[e][o] && fIdx < 0) begin
              fIdx = idx; eAddr = a; eElem = e;
            end
          end else if (!stuckCell(phys(a))) begin
            sim[phys(a)] = ov[e][o];
          end
          idx++;
        end
      end
    end
    total = idx;
    eFail = (fIdx >= 0);
    if (stop && eFail) begin
      int keep;
      keep = (fIdx + 2 < total) ? fIdx + 2 : total;
      while (expQ.size() > keep) void'(expQ.pop_back());
      total = keep;
    end
  endtask

  task automatic runAlgo(input int algo, input bit stop, input int fk, input int fa,
                         input int fb, input bit midStart, input int formula);
    int total, eAddr, eElem, cyc;
    bit eFail;
    faultKind = fk; faultA = fa; faultB = fb;
    buildPlan(algo, stop, total, eFail, eAddr, eElem);
    @(negedge clk);
    algoSel = 3'(algo);
    stopOnFail = stop;
    issued = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R10 busy after start", int'(busy), 1);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (midStart && cyc == 20) start = 1'b1;
      if (midStart && cyc == 21) start = 1'b0;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 run timeout: got done=0 expected 1");
    end
    check(busy == 1'b0, "R10 busy low at done", int'(busy), 0);
    check(expQ.size() == 0, "R5 all expected operations issued", expQ.size(), 0);
    check(issued == total, "R5 operation count", issued, total);
    if (formula > 0) check(issued == formula, "R5 algorithm length", issued, formula);
    check(fail == eFail, stop ? "R7 fail flag" : "R8 fail flag", int'(fail), int'(eFail));
    if (eFail) begin
      check(int'(failAddr) == eAddr, "R6 failAddr", int'(failAddr), eAddr);
      check(int'(failElem) == eElem, "R6 failElem", int'(failElem), eElem);
    end
    repeat (3) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R9 done held", int'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < N; c++) ram[c] = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !memEn && !memWe, "R1 reset state",
          int'({busy, done, fail, memEn, memWe}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !fail && !memEn, "R1 idle after reset",
          int'({busy, done, fail, memEn}), 0);
    runAlgo(0, 1'b1, 0, 0, 0, 1'b0, 5 * N);     // R2 MATS+
    runAlgo(1, 1'b1, 0, 0, 0, 1'b0, 6 * N);     // R2 MATS++
    runAlgo(2, 1'b1, 0, 0, 0, 1'b0, 6 * N);     // R2 March X
    runAlgo(3, 1'b1, 0, 0, 0, 1'b0, 10 * N);    // R2 R5 March C-
    runAlgo(4, 1'b1, 0, 0, 0, 1'b1, 8 * N);     // R5 R9 March Y, start while busy
    runAlgo(5, 1'b1, 0, 0, 0, 1'b0, 15 * N);    // R2 March A
    runAlgo(7, 1'b1, 0, 0, 0, 1'b0, 5 * N);     // R2 spare code runs MATS+
    runAlgo(3, 1'b1, 1, 6, 0, 1'b0, 0);         // R6 R7 stuck-at-0, halt
    runAlgo(3, 1'b0, 1, 6, 1, 1'b0, 0);         // R8 stuck-at-1, continue
    runAlgo(2, 1'b1, 2, 5, 9, 1'b0, 0);         // R6 decoder alias
    runAlgo(0, 1'b0, 1, N - 1, 1, 1'b0, 0);     // R8 top cell stuck
    runAlgo(4, 1'b1, 1, 0, 1, 1'b0, 0);         // R7 bottom cell stuck
    runAlgo(1, 1'b1, 0, 0, 0, 1'b0, 6 * N);     // R9 start clears fail
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule